// File: doc/BRIEF.md
# Delayed Read Tracker

This block keeps the bookkeeping for delayed reads that cross one direction of a transparent bus-to-bus bridge. A read attempt arrives as an address plus a read command. The block answers in the same cycle with one of four results: the attempt is taken as a new entry, it merges into an entry already held, it is refused for lack of room, or it receives the completed data of the oldest entry. Up to three entries are kept, oldest first. The data path reports completion for the oldest entry and says when that entry's data sits first in its own data queue.

A discard timer guards the oldest entry once it is complete and its data is ready. The timer holds one of two load values. If the initiator does not come back in time, the entry is dropped and the data path is told to flush the matching data. An error pulse is raised as well, if error reporting is enabled. The timer is a three-state machine: `TMR_IDLE` (no timer runs), `TMR_COUNT` (counting down) and `TMR_EXPIRE` (a one-cycle drop state). Its transitions are:
- IDLE to COUNT, when the start condition holds and no hand-over takes place.
- COUNT to IDLE, on a hand-over.
- COUNT to EXPIRE, when the count reaches zero.
- EXPIRE to IDLE, always.

Top module: `delayed_read_tracker`

## Requirements
- R1: At most three entries are held (`occupancy` is never above 3). A request that matches no held entry while three are held raises `req_refuse`, and `occupancy` stays the same.
- R2: A request whose address and command both equal those of a held entry raises `req_dup` and allocates nothing. The same address with a different command is a new entry and raises `req_accept`.
- R3: The discard timer starts only on a clock edge at which the oldest entry is complete and `data_at_head` is high. While `data_at_head` is low, no discard ever happens.
- R4: With `tmo_sel`=1 the timer length is 1024 clocks, and with `tmo_sel`=0 it is 32768 clocks. `discard` is first high after the N-th clock edge that follows the edge which first saw the start condition.
- R5: On expiry, `discard` and `pop_data` are high together for exactly one cycle, and the oldest entry is removed at the end of that cycle.
- R6: `serr` pulses together with `discard` when `serr_en`=1 and stays low when `serr_en`=0.
- R7: A request that matches the complete oldest entry while `data_at_head` is high and before expiry raises `req_hit`. That entry is retired, its timer stops without a discard, and the next entry moves to the head.
- R8: Entries leave in arrival order. `head_addr`/`head_cmd` show the oldest held entry, and `cpl_valid` marks only that entry complete.
- R9: A synchronous reset (`rst`=1 at a clock edge) empties the queue and stops the timer, so no discard follows and an earlier address is accepted anew.
- R10: In the expiry cycle, a request that matches the entry being dropped is neither a hit nor a duplicate. It is accepted as a fresh entry, which arrives not complete.
- R11: `cpl_valid` has no effect when the queue is empty. An entry pushed afterwards is not complete and starts no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A read attempt is presented this cycle |
| req_addr | input | 32 | Address of the read attempt |
| req_cmd | input | 4 | Read command of the attempt |
| req_accept | output | 1 | Attempt allocated as a new entry |
| req_dup | output | 1 | Attempt matches a held entry, nothing allocated |
| req_refuse | output | 1 | Attempt refused, all entries in use |
| req_hit | output | 1 | Attempt receives the completed oldest entry, which retires |
| cpl_valid | input | 1 | Read data has returned for the oldest entry |
| data_at_head | input | 1 | The oldest entry's data is first in the data queue |
| tmo_sel | input | 1 | Timer length select: 1 = 1024 clocks, 0 = 32768 clocks |
| serr_en | input | 1 | Enables the error pulse on discard |
| discard | output | 1 | One-cycle pulse: oldest entry dropped by timer expiry |
| pop_data | output | 1 | One-cycle pulse: flush the oldest entry's data |
| serr | output | 1 | One-cycle error pulse on discard when enabled |
| head_addr | output | 32 | Address of the oldest held entry |
| head_cmd | output | 4 | Command of the oldest held entry |
| occupancy | output | 2 | Number of held entries |

## Verification
A wrong internal state shows up at the ports quickly. A stale valid or completion flag turns up as a wrong response code on the next request to that address. A wrong head pointer turns up as the wrong address on `head_addr` at the next clock. Timer faults take longer to appear: a counter loaded or started wrongly is seen only when `discard` comes early, comes late, or never comes, so the expected expiry edge is counted from the start condition. The expiry cycle is the riskiest single cycle, because a pop and a push can meet there, and it is driven directly.

// File: rtl/drq_pkg.sv
package drq_pkg;
    typedef enum logic [1:0] {
        TMR_IDLE,
        TMR_COUNT,
        TMR_EXPIRE
    } tmr_state_t;
endpackage

// File: rtl/drq_slots.sv
module drq_slots #(
    parameter int DEPTH = 3,
    parameter int AW    = 32,
    parameter int CW    = 4,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int OW    = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic [CW-1:0]                push_cmd,
    input  logic                         pop,
    input  logic                         mark_cpl,
    output logic [DEPTH-1:0]             slot_vld,
    output logic [DEPTH-1:0][AW-1:0]     slot_addr,
    output logic [DEPTH-1:0][CW-1:0]     slot_cmd,
    output logic [IW-1:0]                head_idx,
    output logic                         head_done,
    output logic [OW-1:0]                count
);
    logic [DEPTH-1:0] done_q;
    logic [IW-1:0]    tail_idx;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_done = slot_vld[head_idx] & done_q[head_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
            done_q   <= '0;
            head_idx <= '0;
            tail_idx <= '0;
            count    <= '0;
        end else begin
            if (mark_cpl && count != '0 && !pop)
                done_q[head_idx] <= 1'b1;
            if (pop) begin
                slot_vld[head_idx] <= 1'b0;
                done_q[head_idx]   <= 1'b0;
                head_idx           <= wrap_inc(head_idx);
            end
            if (push) begin
                slot_vld[tail_idx] <= 1'b1;
                done_q[tail_idx]   <= 1'b0;
                tail_idx           <= wrap_inc(tail_idx);
            end
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail_idx] <= push_addr;
            slot_cmd[tail_idx]  <= push_cmd;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= OW'(DEPTH)); // R1
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        push && !pop |-> count < OW'(DEPTH)); // R1
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0); // R5
endmodule

// File: rtl/drq_match.sv
module drq_match #(
    parameter int DEPTH = 3,
    parameter int AW    = 32,
    parameter int CW    = 4,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]             slot_vld,
    input  logic [DEPTH-1:0][AW-1:0]     slot_addr,
    input  logic [DEPTH-1:0][CW-1:0]     slot_cmd,
    input  logic [AW-1:0]                cmp_addr,
    input  logic [CW-1:0]                cmp_cmd,
    input  logic [IW-1:0]                head_idx,
    input  logic                         mask_head,
    output logic                         any_match,
    output logic                         head_match
);
    logic [DEPTH-1:0] raw_match;
    logic [DEPTH-1:0] live_match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign raw_match[i]  = slot_vld[i] && slot_addr[i] == cmp_addr
                               && slot_cmd[i] == cmp_cmd;
        assign live_match[i] = raw_match[i]
                               && !(mask_head && head_idx == IW'(i));
    end

    assign any_match  = |live_match;
    assign head_match = raw_match[head_idx];
endmodule

// File: rtl/drq_timer.sv
module drq_timer
    import drq_pkg::*;
#(
    parameter int SHORT_LOG2 = 10,
    parameter int LONG_LOG2  = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic stop,
    input  logic sel_short,
    output logic expire,
    output logic running
);
    localparam int TW = (LONG_LOG2 > SHORT_LOG2) ? LONG_LOG2 : SHORT_LOG2;
    localparam logic [TW-1:0] SHORT_LOAD = TW'((1 << SHORT_LOG2) - 1);
    localparam logic [TW-1:0] LONG_LOAD  = TW'((1 << LONG_LOG2) - 1);

    tmr_state_t      state_q, state_d;
    logic [TW-1:0]   cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE:   if (arm && !stop) state_d = TMR_COUNT;
            TMR_COUNT: begin
                if (stop)              state_d = TMR_IDLE;
                else if (cnt_q == '0)  state_d = TMR_EXPIRE;
            end
            TMR_EXPIRE: state_d = TMR_IDLE;
            default:    state_d = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TMR_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (state_q == TMR_IDLE && state_d == TMR_COUNT)
            cnt_q <= sel_short ? SHORT_LOAD : LONG_LOAD;
        else if (state_q == TMR_COUNT && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        expire  = 1'b0;
        running = 1'b0;
        unique case (state_q)
            TMR_IDLE:   ;
            TMR_COUNT:  running = 1'b1;
            TMR_EXPIRE: expire  = 1'b1;
            default:    ;
        endcase
    end

    AST_EXPIRE_FOLLOWS_COUNT: assert property (@(posedge clk) disable iff (rst)
        state_q == TMR_EXPIRE |-> $past(state_q) == TMR_COUNT); // R4
    AST_EXPIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        state_q == TMR_EXPIRE |=> state_q == TMR_IDLE); // R5
    AST_COUNT_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(arm)); // R3
endmodule

// File: rtl/delayed_read_tracker.sv
module delayed_read_tracker #(
    parameter int DEPTH      = 3,
    parameter int AW         = 32,
    parameter int CW         = 4,
    parameter int SHORT_LOG2 = 10,
    parameter int LONG_LOG2  = 15,
    parameter int IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int OW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_cmd,
    output logic          req_accept,
    output logic          req_dup,
    output logic          req_refuse,
    output logic          req_hit,
    input  logic          cpl_valid,
    input  logic          data_at_head,
    input  logic          tmo_sel,
    input  logic          serr_en,
    output logic          discard,
    output logic          pop_data,
    output logic          serr,
    output logic [AW-1:0] head_addr,
    output logic [CW-1:0] head_cmd,
    output logic [OW-1:0] occupancy
);
    logic [DEPTH-1:0]         slot_vld;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][CW-1:0] slot_cmd;
    logic [IW-1:0]            head_idx;
    logic                     head_done;
    logic                     any_match, head_match;
    logic                     expiring, running;
    logic                     ready_head, full, fresh;

    assign full       = occupancy == OW'(DEPTH);
    assign ready_head = head_done && data_at_head;

    assign req_hit    = req_valid && head_match && ready_head && !expiring;
    assign fresh      = req_valid && !req_hit && !any_match;
    assign req_dup    = req_valid && !req_hit && any_match;
    assign req_refuse = fresh && full;
    assign req_accept = fresh && !full;

    assign discard    = expiring;
    assign pop_data   = expiring;
    assign serr       = expiring && serr_en;

    assign head_addr  = slot_addr[head_idx];
    assign head_cmd   = slot_cmd[head_idx];

    drq_slots #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .IW(IW), .OW(OW)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .push      (req_accept),
        .push_addr (req_addr),
        .push_cmd  (req_cmd),
        .pop       (req_hit || expiring),
        .mark_cpl  (cpl_valid),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_cmd  (slot_cmd),
        .head_idx  (head_idx),
        .head_done (head_done),
        .count     (occupancy)
    );

    drq_match #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .IW(IW)) u_match (
        .slot_vld   (slot_vld),
        .slot_addr  (slot_addr),
        .slot_cmd   (slot_cmd),
        .cmp_addr   (req_addr),
        .cmp_cmd    (req_cmd),
        .head_idx   (head_idx),
        .mask_head  (expiring),
        .any_match  (any_match),
        .head_match (head_match)
    );

    drq_timer #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .arm       (ready_head),
        .stop      (req_hit),
        .sel_short (tmo_sel),
        .expire    (expiring),
        .running   (running)
    );

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_accept, req_dup, req_refuse, req_hit})); // R2
    AST_SERR_WITH_DISCARD: assert property (@(posedge clk) disable iff (rst)
        serr |-> discard); // R6
    AST_HIT_RETIRES: assert property (@(posedge clk) disable iff (rst)
        req_hit |=> occupancy == $past(occupancy) - 1'b1); // R7
    AST_HIT_STOPS_TIMER: assert property (@(posedge clk) disable iff (rst)
        req_hit && running |=> !running); // R7
    AST_DISCARD_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        discard |-> occupancy != '0); // R5
endmodule

// File: tb/delayed_read_tracker_bench.sv
module delayed_read_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        req_accept, req_dup, req_refuse, req_hit;
    logic        cpl_valid = 1'b0;
    logic        data_at_head = 1'b0;
    logic        tmo_sel = 1'b1;
    logic        serr_en = 1'b1;
    logic        discard, pop_data, serr;
    logic [31:0] head_addr;
    logic [3:0]  head_cmd;
    logic [1:0]  occupancy;

    int n_chk  = 0;
    int n_fail = 0;

    localparam int SHORT_N = 1024;
    localparam int LONG_N  = 32768;
    localparam int RSP_ACC = 0, RSP_DUP = 1, RSP_REF = 2, RSP_HIT = 3;

    // vector: addr[39:8], cmd[7:4], response code[3:2], occupancy after[1:0]
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        {32'h0000_1000, 4'h6, 2'd0, 2'd1},
        {32'h0000_1000, 4'h6, 2'd1, 2'd1},
        {32'h0000_1000, 4'hE, 2'd0, 2'd2},
        {32'h0000_2000, 4'h6, 2'd0, 2'd3},
        {32'h0000_3000, 4'h6, 2'd2, 2'd3},
        {32'h0000_2000, 4'h6, 2'd1, 2'd3},
        {32'h0000_1004, 4'h6, 2'd2, 2'd3},
        {32'h0000_1000, 4'hE, 2'd1, 2'd3}
    };

    always #4 clk = ~clk;

    delayed_read_tracker u_delayed_read_tracker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_accept(req_accept), .req_dup(req_dup),
        .req_refuse(req_refuse), .req_hit(req_hit), .cpl_valid(cpl_valid),
        .data_at_head(data_at_head), .tmo_sel(tmo_sel), .serr_en(serr_en),
        .discard(discard), .pop_data(pop_data), .serr(serr),
        .head_addr(head_addr), .head_cmd(head_cmd), .occupancy(occupancy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rsp_code();
        if (req_accept) return RSP_ACC;
        if (req_dup)    return RSP_DUP;
        if (req_refuse) return RSP_REF;
        if (req_hit)    return RSP_HIT;
        return 7;
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic send(input logic [31:0] a, input logic [3:0] c, output int rsp);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        #1 rsp = rsp_code();
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpl_pulse();
        cpl_valid = 1'b1;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // counts posedges from a negedge until discard is seen; stops at that negedge
    task automatic wait_discard(input int limit, output int k);
        k = 0;
        while (k < limit) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (discard) break;
        end
    endtask

    task automatic count_quiet(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (discard) hits++;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int rsp, k, q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset occupancy", occupancy, 0);
        chk("R9 reset discard", discard, 0);

        // R1, R2: table of requests with no completions
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][39:8], VEC[v][7:4], rsp);
            chk($sformatf("R2/R1 vector %0d response", v), rsp, VEC[v][3:2]);
            chk($sformatf("R1 vector %0d occupancy", v), occupancy, VEC[v][1:0]);
        end
        chk("R8 head address oldest", head_addr, 32'h1000);
        chk("R8 head command oldest", head_cmd, 4'h6);

        // R4, R5, R6: short timer expiry with error reporting on
        tmo_sel = 1'b1; serr_en = 1'b1; data_at_head = 1'b1;
        cpl_pulse();
        wait_discard(SHORT_N + 10, k);
        chk("R4 short timer length", k, SHORT_N + 1);
        chk("R5 pop_data with discard", pop_data, 1);
        chk("R6 serr when enabled", serr, 1);
        chk("R5 occupancy before drop", occupancy, 3);
        @(negedge clk);
        chk("R5 discard one cycle", discard, 0);
        chk("R5 occupancy after drop", occupancy, 2);
        chk("R8 next head address", head_addr, 32'h1000);
        chk("R8 next head command", head_cmd, 4'hE);

        // R7: hand-over before expiry
        cpl_pulse();
        count_quiet(100, q);
        chk("R7 no discard before hit", q, 0);
        send(32'h1000, 4'hE, rsp);
        chk("R7 hit response", rsp, RSP_HIT);
        chk("R7 entry retired", occupancy, 1);
        chk("R8 head after hit", head_addr, 32'h2000);
        count_quiet(SHORT_N + 20, q);
        chk("R7 timer stopped, next not complete", q, 0);

        // R3: completion without data at head must not start the timer
        data_at_head = 1'b0;
        cpl_pulse();
        count_quiet(SHORT_N + 80, q);
        chk("R3 no discard without data at head", q, 0);
        chk("R3 entry still held", occupancy, 1);
        send(32'h2000, 4'h6, rsp);
        chk("R3 complete head without data is duplicate", rsp, RSP_DUP);
        serr_en = 1'b0;
        data_at_head = 1'b1;
        wait_discard(SHORT_N + 10, k);
        chk("R3 timer starts on data at head", k, SHORT_N + 1);
        chk("R6 serr gated off", serr, 0);

        // R10: request matching the head in its expiry cycle
        send(32'h2000, 4'h6, rsp);
        chk("R10 expiry-cycle match accepted fresh", rsp, RSP_ACC);
        chk("R10 occupancy after pop and push", occupancy, 1);
        chk("R10 head is fresh entry", head_addr, 32'h2000);
        count_quiet(SHORT_N + 20, q);
        chk("R10 fresh entry not complete", q, 0);

        // R4: long timer length
        tmo_sel = 1'b0;
        cpl_pulse();
        wait_discard(LONG_N + 10, k);
        chk("R4 long timer length", k, LONG_N + 1);
        @(negedge clk);
        chk("R5 queue empty after drop", occupancy, 0);

        // R11: completion on empty queue ignored
        tmo_sel = 1'b1;
        cpl_pulse();
        send(32'h4000, 4'h7, rsp);
        chk("R11 push after empty completion", rsp, RSP_ACC);
        count_quiet(SHORT_N + 20, q);
        chk("R11 no discard for incomplete entry", q, 0);

        // R9: reset while timer runs
        cpl_pulse();
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 occupancy cleared", occupancy, 0);
        count_quiet(SHORT_N + 20, q);
        chk("R9 timer stopped by reset", q, 0);
        send(32'h4000, 4'h7, rsp);
        chk("R9 earlier address accepted anew", rsp, RSP_ACC);

        finish_run();
    end
endmodule